// File: doc/BRIEF.md
# Three-Format 16-bit Instruction Decoder

This block decodes one 16-bit instruction word per strobe. The top bits of the word select one of three layouts: a register/register layout, a register/immediate layout, or a conditional-branch layout. The block pulls out the fields of the selected layout and maps the word onto one flat operation index. It also reports how many bytes the instruction occupies and whether the encoding is illegal.

Some register/register operations carry a 32-bit literal after the opcode word, so they occupy 6 bytes. All other legal words occupy 2 bytes. An illegal word reports a length of 0. A fetch unit that advances its program counter by the reported length therefore stays on the faulting instruction while the bad-instruction exception is taken.

The block does not fetch the trailing literal and does not execute anything. Results are registered and appear one clock after the input strobe.

Top module: `insn_decoder`

## Requirements
- R1: The format output reads 1 when bit 15 is 0, 2 when bits 15:14 are 10, and 3 when bits 15:14 are 11. Fields that the selected format does not define read 0.
- R2: In format 1, `ra` is bits 7:4 and `rb` is bits 3:0. The opcode byte is bits 15:8. Opcodes 0x00 to 0x0E give the op index equal to the opcode. Opcodes 0x19 to 0x39 give the op index equal to the opcode minus 10, which covers indices 15 to 47.
- R3: In format 2, `ra` is bits 11:8 and `imm` is bits 7:0, unsigned. The op index is 48 plus bits 13:12: 48 is increment, 49 is decrement, 50 reads a special register and 51 writes one. Format 2 is never illegal.
- R4: In format 3, `cond` is bits 13:10 and `boff` is bits 9:0. For condition values 0 to 9 the op index is 52 plus the condition.
- R5: These format 1 opcodes report a length of 6: 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, and 0x36 to 0x39.
- R6: Every other legal word reports a length of 2.
- R7: The following words are illegal: a format 1 opcode in 0x0F to 0x18 or above 0x39, and a format 3 condition of 10 to 15. An illegal word raises `illegal` and reports op index 63 and a length of 0, so the program counter is not advanced. The operation index of a legal word is never 63.
- R8: Every output reflects the word that was strobed on the previous clock edge. `out_valid` is high exactly in the cycle after `in_valid`. While no word is strobed, `out_valid` stays low and the decoded outputs hold their values.
- R9: After reset, `out_valid`, `illegal` and every decoded output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: `insn` holds a word to decode |
| insn | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result is present |
| fmt | output | 2 | Format: 1, 2 or 3 |
| op | output | 6 | Flat operation index; 63 means illegal |
| ra | output | 4 | First register field |
| rb | output | 4 | Second register field |
| imm | output | 8 | Unsigned immediate of format 2 |
| cond | output | 4 | Branch condition of format 3 |
| boff | output | 10 | Raw branch offset of format 3 |
| len | output | 3 | Instruction length in bytes: 6, 2, or 0 when illegal |
| illegal | output | 1 | Bad-instruction exception request |

## Verification
The hardest cases to reach are the boundary opcodes: the illegal opcode window that sits between the two legal format 1 ranges, and the few long opcodes that sit right beside short or illegal neighbours. Directed picks tend to miss these. The stimulus therefore drives every one of the 65536 words back to back. It inserts idle cycles at intervals, so the hold behaviour is checked against whatever word was decoded last. Each output is compared with a model of the requirements that runs inside the bench.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int OP_W      = 6,
  parameter int LEN_W     = 3,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 6,
  parameter int F2_BASE   = 48,
  parameter int F3_BASE   = 52,
  parameter int MAX_COND  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      insn,
  output logic             out_valid,
  output logic [1:0]       fmt,
  output logic [OP_W-1:0]  op,
  output logic [3:0]       ra,
  output logic [3:0]       rb,
  output logic [7:0]       imm,
  output logic [3:0]       cond,
  output logic [9:0]       boff,
  output logic [LEN_W-1:0] len,
  output logic             illegal
);

  localparam logic [OP_W-1:0] OP_BAD = {OP_W{1'b1}};

  logic [7:0] opc;
  logic       f1_lo, f1_hi, f1_long, bad;
  logic [1:0]       n_fmt;
  logic [OP_W-1:0]  n_op;
  logic [3:0]       n_ra, n_rb, n_cond;
  logic [7:0]       n_imm;
  logic [9:0]       n_boff;
  logic [LEN_W-1:0] n_len;

  assign opc   = insn[15:8];
  assign f1_lo = (opc <= 8'h0E);
  assign f1_hi = (opc >= 8'h19) && (opc <= 8'h39);

  always_comb begin
    case (opc)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
      8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39:
        f1_long = 1'b1;
      default: f1_long = 1'b0;
    endcase
  end

  always_comb begin
    n_fmt  = 2'd0;
    n_op   = '0;
    n_ra   = '0;
    n_rb   = '0;
    n_imm  = '0;
    n_cond = '0;
    n_boff = '0;
    n_len  = LEN_W'(SHORT_LEN);
    bad    = 1'b0;
    if (!insn[15]) begin
      n_fmt = 2'd1;
      n_ra  = insn[7:4];
      n_rb  = insn[3:0];
      if (f1_lo)      n_op = OP_W'(opc);
      else if (f1_hi) n_op = OP_W'(opc - 8'd10);
      else            bad  = 1'b1;
      if (f1_long)    n_len = LEN_W'(LONG_LEN);
    end else if (!insn[14]) begin
      n_fmt = 2'd2;
      n_ra  = insn[11:8];
      n_imm = insn[7:0];
      n_op  = OP_W'(F2_BASE + int'(insn[13:12]));
    end else begin
      n_fmt  = 2'd3;
      n_cond = insn[13:10];
      n_boff = insn[9:0];
      if (int'(insn[13:10]) > MAX_COND) bad  = 1'b1;
      else                              n_op = OP_W'(F3_BASE + int'(insn[13:10]));
    end
    if (bad) begin
      n_op  = OP_BAD;
      n_len = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fmt <= '0; op <= '0; ra <= '0; rb <= '0; imm <= '0;
      cond <= '0; boff <= '0; len <= '0; illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt <= n_fmt; op <= n_op; ra <= n_ra; rb <= n_rb; imm <= n_imm;
        cond <= n_cond; boff <= n_boff; len <= n_len; illegal <= bad;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid && $stable(op) && $stable(len)); // R8
  AST_FMT_ONE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !insn[15]) |=> fmt == 2'd1); // R1
  AST_F2_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && insn[15:14] == 2'b10) |=> !illegal && len == LEN_W'(SHORT_LEN)); // R3
  AST_BAD_COND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && insn[15:14] == 2'b11 && insn[13:10] > 4'd9) |=> illegal); // R4
  AST_ILL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && illegal) |-> (op == OP_BAD && len == '0)); // R7
  AST_LEGAL_OP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !illegal) |-> (op != OP_BAD && len != '0)); // R7

endmodule

// File: tb/sim_insn_decoder.sv
module sim_insn_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] insn = '0;
  logic        out_valid, illegal;
  logic [1:0]  fmt;
  logic [5:0]  op;
  logic [3:0]  ra, rb, cond;
  logic [7:0]  imm;
  logic [9:0]  boff;
  logic [2:0]  len;

  typedef struct packed {
    logic [1:0] fmt; logic [5:0] op; logic [3:0] ra; logic [3:0] rb;
    logic [7:0] imm; logic [3:0] cond; logic [9:0] boff; logic [2:0] len; logic ill;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   checks = 0, fails = 0;
  bit   seen = 0, done = 0;

  always #2 clk = ~clk;

  insn_decoder u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .out_valid(out_valid), .fmt(fmt), .op(op), .ra(ra), .rb(rb), .imm(imm),
    .cond(cond), .boff(boff), .len(len), .illegal(illegal));

  function automatic exp_t model(input logic [15:0] w);
    exp_t e = '0;
    int b = int'(w[15:8]);
    if (w[15] == 1'b0) begin
      e.fmt = 2'd1; e.ra = w[7:4]; e.rb = w[3:0];
      if (b <= 14) e.op = 6'(b);
      else if (b >= 25 && b <= 57) e.op = 6'(b - 10);
      else e.ill = 1'b1;
      e.len = 3'd2;
      if (b == 1 || b == 3 || b == 8 || b == 9 || b == 12 || b == 13 || b == 26 ||
          b == 27 || b == 29 || b == 31 || b == 32 || b == 34 || b == 36 || b == 48 ||
          (b >= 54 && b <= 57)) e.len = 3'd6;
    end else if (w[14] == 1'b0) begin
      e.fmt = 2'd2; e.ra = w[11:8]; e.imm = w[7:0];
      e.op = 6'(48 + int'(w[13:12])); e.len = 3'd2;
    end else begin
      e.fmt = 2'd3; e.cond = w[13:10]; e.boff = w[9:0]; e.len = 3'd2;
      if (int'(w[13:10]) > 9) e.ill = 1'b1;
      else e.op = 6'(52 + int'(w[13:10]));
    end
    if (e.ill) begin e.op = 6'd63; e.len = 3'd0; end
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cmp(input exp_t e, input string ctx);
    chk({"R1 fmt ", ctx}, int'(fmt), int'(e.fmt));
    chk({"R2/R3/R4 op ", ctx}, int'(op), int'(e.op));
    chk({"R2/R3 ra ", ctx}, int'(ra), int'(e.ra));
    chk({"R2 rb ", ctx}, int'(rb), int'(e.rb));
    chk({"R3 imm ", ctx}, int'(imm), int'(e.imm));
    chk({"R4 cond ", ctx}, int'(cond), int'(e.cond));
    chk({"R4 boff ", ctx}, int'(boff), int'(e.boff));
    chk({"R5/R6 len ", ctx}, int'(len), int'(e.len));
    chk({"R7 illegal ", ctx}, int'(illegal), int'(e.ill));
  endtask

  task automatic drive(input logic [15:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1; insn = w;
    q.push_back(model(w));
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; insn = 16'hFFFF;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) chk("R8 unexpected out_valid", 1, 0);
        else begin
          last = q.pop_front();
          seen = 1;
          cmp(last, "decode");
        end
      end else if (seen) begin
        cmp(last, "R8 hold");
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 op", int'(op), 0);
    chk("R9 len", int'(len), 0);
    chk("R9 illegal", int'(illegal), 0);
    chk("R9 fmt", int'(fmt), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      drive(16'(i));
      if (i % 97 == 96) begin idle(); idle(); end
    end
    idle();
    repeat (4) @(posedge clk);
    chk("R8 queue drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule